// File: doc/BRIEF.md
# Sixteen-bit opcode-mapped ALU

This block is a purely combinational arithmetic logic unit. It has two operands and a four-bit operation code, and it returns a result of the same width plus an overflow flag. The opcode map is sparse. One adder/subtracter serves both the unsigned and the signed forms of addition and subtraction. Four bitwise operations share one per-bit logic slice. The load-upper move shifts the low half of operand A into the high half of the result. Two less-than tests return a single-bit flag in bit 0, one treating the operands as magnitudes and one as two's-complement numbers.

A datapath feeds the block directly, and the result is valid once the inputs settle. The overflow flag means something only for the signed add and subtract codes. For every other code it is held low, and this includes the unsigned add and subtract codes, which wrap modulo 2^16. The five codes that have no operation give a zero result.

Top module: `opmap_alu`

## Requirements
- R1: Opcodes 0 (unsigned add) and 8 (signed add) give result = (A + B) mod 2^16.
- R2: Opcodes 1 (unsigned subtract) and 9 (signed subtract) give result = (A - B) mod 2^16.
- R3: The overflow output is 0 for every opcode other than 8 and 9, including opcodes 0 and 1.
- R4: For opcodes 8 and 9 the overflow output is 1 exactly when the true two's-complement sum (opcode 8) or difference (opcode 9) lies outside -32768..32767.
- R5: Opcode 2 gives A AND B, opcode 3 gives A OR B, and opcode 5 gives A XOR B, bit by bit.
- R6: Opcode 4 gives the bitwise inverse of A, and operand B has no effect on the result.
- R7: Opcode 6 gives result[15:8] = A[7:0] and result[7:0] = 0, and operand B has no effect on the result.
- R8: Opcode 7 gives result bit 0 = 1 when A < B as unsigned numbers and 0 otherwise, with result bits 15..1 at 0.
- R9: Opcode 15 gives result bit 0 = 1 when A < B as two's-complement numbers and 0 otherwise, with result bits 15..1 at 0.
- R10: Opcodes 10 through 14 give a result of 0 with overflow at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| opcode | input | 4 | Operation select |
| result | output | 16 | Operation result |
| ovf | output | 1 | Signed overflow flag, valid for opcodes 8 and 9 only |

## Verification
The cases that are hardest to reach are operand pairs whose signed sum or difference lands exactly on -32768 or 32767, or one step beyond. The other hard cases are less-than tests where the signed and unsigned answers disagree because the two signs differ. Random operands seldom produce either. The stimulus therefore crosses every opcode with a fixed table of extreme values: both sign-boundary neighbours, all-ones, alternating patterns and byte-edge values. That sweep is followed by pseudo-random pairs, and the expected result and overflow are computed from integer arithmetic on the operands.

// File: rtl/opmap_alu_pkg.sv
package opmap_alu_pkg;

  localparam logic [3:0] OPC_ADDU = 4'd0;
  localparam logic [3:0] OPC_SUBU = 4'd1;
  localparam logic [3:0] OPC_AND  = 4'd2;
  localparam logic [3:0] OPC_OR   = 4'd3;
  localparam logic [3:0] OPC_NOT  = 4'd4;
  localparam logic [3:0] OPC_XOR  = 4'd5;
  localparam logic [3:0] OPC_LUP  = 4'd6;
  localparam logic [3:0] OPC_LTU  = 4'd7;
  localparam logic [3:0] OPC_ADDS = 4'd8;
  localparam logic [3:0] OPC_SUBS = 4'd9;
  localparam logic [3:0] OPC_LTS  = 4'd15;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_INV = 2'd3
  } logic_kind_e;

endpackage

// File: rtl/opmap_alu_addsub.sv
module opmap_alu_addsub #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             sub_en,
  output logic [WIDTH-1:0] sum,
  output logic             sgn_ovf
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff   = in_b ^ {WIDTH{sub_en}};
    sum     = in_a + b_eff + {{(WIDTH-1){1'b0}}, sub_en};
    sgn_ovf = (in_a[MSB] == b_eff[MSB]) && (sum[MSB] != in_a[MSB]);
  end
endmodule

// File: rtl/opmap_alu_compare.sv
module opmap_alu_compare #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             signed_mode,
  output logic             less
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] bias;
  logic [WIDTH-1:0] a_key;
  logic [WIDTH-1:0] b_key;

  always_comb begin
    bias       = '0;
    bias[MSB]  = signed_mode;
    a_key      = in_a ^ bias;
    b_key      = in_b ^ bias;
    less       = a_key < b_key;
  end
endmodule

// File: rtl/opmap_alu_logic.sv
module opmap_alu_logic
  import opmap_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic_kind_e      kind,
  output logic [WIDTH-1:0] y
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    always_comb begin
      unique case (kind)
        LG_AND:  y[i] = in_a[i] & in_b[i];
        LG_OR:   y[i] = in_a[i] | in_b[i];
        LG_XOR:  y[i] = in_a[i] ^ in_b[i];
        default: y[i] = ~in_a[i];
      endcase
    end
  end
endmodule

// File: rtl/opmap_alu.sv
module opmap_alu
  import opmap_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       opcode,
  output logic [WIDTH-1:0] result,
  output logic             ovf
);
  localparam int unsigned HALF = WIDTH / 2;

  logic [WIDTH-1:0] as_sum;
  logic             as_ovf;
  logic             cmp_less;
  logic [WIDTH-1:0] lg_y;
  logic_kind_e      lg_kind;
  logic [WIDTH-1:0] lup_val;

  // Bit 0 of the opcode selects subtract for codes 0/1 and 8/9.
  opmap_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .in_a    (opa),
    .in_b    (opb),
    .sub_en  (opcode[0]),
    .sum     (as_sum),
    .sgn_ovf (as_ovf)
  );

  // Bit 3 of the opcode separates signed (15) from unsigned (7) compare.
  opmap_alu_compare #(.WIDTH(WIDTH)) u_cmp (
    .in_a        (opa),
    .in_b        (opb),
    .signed_mode (opcode[3]),
    .less        (cmp_less)
  );

  always_comb begin
    unique case (opcode)
      OPC_AND: lg_kind = LG_AND;
      OPC_OR:  lg_kind = LG_OR;
      OPC_XOR: lg_kind = LG_XOR;
      default: lg_kind = LG_INV;
    endcase
  end

  opmap_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .in_a (opa),
    .in_b (opb),
    .kind (lg_kind),
    .y    (lg_y)
  );

  always_comb begin
    lup_val = {opa[HALF-1:0], {(WIDTH-HALF){1'b0}}};
  end

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    unique case (opcode)
      OPC_ADDU, OPC_SUBU: result = as_sum;
      OPC_ADDS, OPC_SUBS: begin
        result = as_sum;
        ovf    = as_ovf;
      end
      OPC_AND, OPC_OR, OPC_XOR, OPC_NOT: result = lg_y;
      OPC_LUP:            result = lup_val;
      OPC_LTU, OPC_LTS:   result[0] = cmp_less;
      default:            result = '0;
    endcase
  end
endmodule

// File: rtl/opmap_alu_chk.sv
module opmap_alu_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [3:0]       opcode,
  input logic [WIDTH-1:0] result,
  input logic             ovf
);
  localparam int unsigned HALF = WIDTH / 2;

  always_comb begin
    if (opcode != 4'd8 && opcode != 4'd9) begin
      p_no_overflow_r3: assert (!ovf);
    end
    if (opcode >= 4'd10 && opcode <= 4'd14) begin
      p_unused_zero_r10: assert (result == '0);
    end
    if (opcode == 4'd6) begin
      p_lup_placement_r7: assert (result[HALF-1:0] == '0 && result[WIDTH-1:HALF] == opa[HALF-1:0]);
    end
    if (opcode == 4'd7) begin
      p_ltu_upper_zero_r8: assert (result[WIDTH-1:1] == '0);
    end
    if (opcode == 4'd15) begin
      p_lts_upper_zero_r9: assert (result[WIDTH-1:1] == '0);
    end
    if (opcode == 4'd4) begin
      p_invert_a_r6: assert ((result ^ opa) == {WIDTH{1'b1}});
    end
    if (opcode == 4'd0 || opcode == 4'd8) begin
      p_add_wrap_r1: assert (result == WIDTH'(opa + opb));
    end
    if (opcode == 4'd1 || opcode == 4'd9) begin
      p_sub_wrap_r2: assert (WIDTH'(result + opb) == opa);
    end
  end
endmodule

bind opmap_alu opmap_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opa    (opa),
  .opb    (opb),
  .opcode (opcode),
  .result (result),
  .ovf    (ovf)
);

// File: tb/opmap_alu_test.sv
module opmap_alu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] a, b, res;
  logic [3:0]  op;
  logic        ovf;
  int          vectors = 0;
  int          misses  = 0;
  bit          done    = 1'b0;
  logic [31:0] lfsr    = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  opmap_alu uut (
    .opa    (a),
    .opb    (b),
    .opcode (op),
    .result (res),
    .ovf    (ovf)
  );

  function automatic logic [15:0] corner(input int k);
    case (k)
      0:  return 16'h0000;  1:  return 16'h0001;
      2:  return 16'h0002;  3:  return 16'h7FFE;
      4:  return 16'h7FFF;  5:  return 16'h8000;
      6:  return 16'h8001;  7:  return 16'hFFFE;
      8:  return 16'hFFFF;  9:  return 16'h00FF;
      10: return 16'hFF00;  11: return 16'h5555;
      12: return 16'hAAAA;  13: return 16'h0100;
      14: return 16'h1234;  default: return 16'hFEDC;
    endcase
  endfunction

  function automatic string res_tag(input logic [3:0] o);
    case (o)
      4'd0, 4'd8:       return "R1";
      4'd1, 4'd9:       return "R2";
      4'd2, 4'd3, 4'd5: return "R5";
      4'd4:             return "R6";
      4'd6:             return "R7";
      4'd7:             return "R8";
      4'd15:            return "R9";
      default:          return "R10";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y);
    int ia, ib, sa, sb, s, e;
    logic [15:0] exp_r;
    logic        exp_o;
    @(negedge clk);
    op = o; a = x; b = y;
    #1;
    ia = int'(x); ib = int'(y);
    sa = x[15] ? ia - 65536 : ia;
    sb = y[15] ? ib - 65536 : ib;
    exp_o = 1'b0;
    case (o)
      4'd0: e = ia + ib;
      4'd1: e = ia - ib;
      4'd2: e = ia & ib;
      4'd3: e = ia | ib;
      4'd4: e = ~ia;
      4'd5: e = ia ^ ib;
      4'd6: e = (ia % 256) * 256;
      4'd7: e = (ia < ib) ? 1 : 0;
      4'd8: begin e = ia + ib; s = sa + sb; exp_o = (s > 32767) || (s < -32768); end
      4'd9: begin e = ia - ib; s = sa - sb; exp_o = (s > 32767) || (s < -32768); end
      4'd15: e = (sa < sb) ? 1 : 0;
      default: e = 0;
    endcase
    exp_r = e[15:0];
    vectors++;
    if (res !== exp_r) begin
      misses++;
      $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h",
               res_tag(o), o, x, y, res, exp_r);
    end
    if (ovf !== exp_o) begin
      misses++;
      $display("FAIL %s op=%0d a=%h b=%h ovf actual=%b expected=%b",
               (o == 4'd8 || o == 4'd9) ? "R4" : "R3", o, x, y, ovf, exp_o);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  initial begin
    rst_n = 1'b0;
    op = 4'd0; a = '0; b = '0;
    // Reset-state vector: zero operands under add give zero, no overflow (R1, R3).
    apply(4'd0, 16'h0000, 16'h0000);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Corner sweep: every opcode against the extreme-value table
    // (R1..R10, overflow boundaries for R4, sign disagreement for R8/R9).
    for (int o = 0; o < 16; o++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          apply(4'(o), corner(i), corner(j));
        end
      end
    end
    // Pseudo-random pairs; B varies freely so R6 and R7 confirm B is ignored.
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 600; k++) begin
        lfsr = step(lfsr);
        apply(4'(o), lfsr[15:0], lfsr[31:16]);
      end
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog (R1..R10 run incomplete) actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule